// File: doc/BRIEF.md
# External Interrupt Input Detector

This block turns one asynchronous external interrupt pin into the request flag that the interrupt controller reads. The pin first passes through a flop synchronizer. The synchronized level is then sampled only on cycles where the machine-cycle strobe is high. A machine cycle is twelve oscillator periods, and the strobe marks one clock in each of them.

A mode register selects one of two sensitivities. In level mode the flag follows the inverted pin sample, so a low pin means a pending request. In edge mode the flag is set when a high sample is followed by a low sample on the next strobe. The flag then stays set until the controller acknowledges the vector or software clears it.

Software can write the flag directly, and such a write acts exactly like a hardware set or clear. The controller's acknowledge clears the flag only in edge mode. In level mode the pin alone governs the request, so a pin that is still low after the handler raises the request again.

Top module: `ext_irq_detect`

## Requirements
- R1: In level mode (`trig_mode` = 0), at every strobe cycle the flag takes the inverse of the synchronized pin sample: a low sample sets it and a high sample clears it.
- R2: In edge mode (`trig_mode` = 1), a strobe sample that is low when the previous strobe sample was high sets the flag on the next clock.
- R3: The pin has an effect only through strobe samples. A pin change reaches the sampler two clocks after it is driven. Pin activity between strobes that is no longer present at the next strobe leaves the flag unchanged.
- R4: In edge mode, `vec_ack` clears the flag on the next clock when no falling sample and no software write occur in the same cycle.
- R5: In level mode, `vec_ack` has no effect on the flag. A pin that is still low at the next strobe after the acknowledge keeps the request asserted.
- R6: When `sw_wr_en` is high, the flag takes `sw_wr_val` on the next clock. This write overrides the pin sample, the falling-edge detection and the acknowledge in that cycle.
- R7: In edge mode, when a falling sample and `vec_ack` occur in the same cycle, the flag is set.
- R8: A synchronous reset leaves the flag at 0 and the mode at level (0). It also sets the remembered previous sample to 1. As a result, a first strobe sample that is low in edge mode counts as a falling edge.
- R9: When `mode_wr_en` is high, `trig_mode` takes `mode_wr_val` on the next clock (0 = level, 1 = edge). Flag logic uses the mode held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_stb | input | 1 | Machine-cycle strobe, one clock per machine cycle |
| pin_raw | input | 1 | Asynchronous external interrupt pin, active low |
| mode_wr_en | input | 1 | Mode register write enable |
| mode_wr_val | input | 1 | Mode value to write (0 level, 1 edge) |
| sw_wr_en | input | 1 | Software flag write enable |
| sw_wr_val | input | 1 | Software flag value |
| vec_ack | input | 1 | Vector acknowledge from the interrupt controller |
| req_flag | output | 1 | Interrupt request flag |
| trig_mode | output | 1 | Current sensitivity mode |

## Verification
The functions that collide most often are the edge-mode falling-sample detection and the controller's acknowledge. A software write can land on top of both. The bench provokes the collision by lowering the pin long enough before a known strobe and raising `vec_ack` in exactly that strobe cycle. It also keeps a dense random phase with a short strobe interval, where all three inputs coincide freely. A behavioural reference model applies the priority software write, then fall, then acknowledge. It is compared with the flag on every clock, so a wrong priority shows up as a flag that drops to 0 instead of staying set.

// File: rtl/eid_pkg.sv
package eid_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_mode_e;

    // Per-cycle sampling result handed from the sampler to the flag logic
    typedef struct packed {
        logic valid;   // strobe cycle: a sample is taken now
        logic level;   // synchronized pin level at this sample
        logic fall;    // high-then-low across two consecutive samples
    } smp_evt_t;

    // Software access to the flag
    typedef struct packed {
        logic wr;
        logic val;
    } sw_cmd_t;

    // Inactive level of an active-low pin
    localparam logic PIN_IDLE = 1'b1;

    function automatic logic fall_seen(input logic prev, input logic cur);
        return prev & ~cur;
    endfunction

endpackage

// File: rtl/eid_sync.sv
module eid_sync #(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= RST_VAL;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/eid_sampler.sv
module eid_sampler
    import eid_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     stb,
    input  logic     din,
    output smp_evt_t evt
);
    logic last_q;

    always_ff @(posedge clk) begin
        if (rst)      last_q <= PIN_IDLE;
        else if (stb) last_q <= din;
    end

    always_comb begin
        evt.valid = stb;
        evt.level = din;
        evt.fall  = stb & fall_seen(last_q, din);
    end
endmodule

// File: rtl/eid_mode_reg.sv
module eid_mode_reg
    import eid_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       wr_val,
    output trig_mode_e mode
);
    always_ff @(posedge clk) begin
        if (rst)        mode <= TRIG_LEVEL;
        else if (wr_en) mode <= trig_mode_e'(wr_val);
    end
endmodule

// File: rtl/eid_flag.sv
module eid_flag
    import eid_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  trig_mode_e mode,
    input  smp_evt_t   evt,
    input  sw_cmd_t    sw,
    input  logic       ack,
    output logic       flag
);
    logic flag_nxt;

    always_comb begin
        flag_nxt = flag;
        if (sw.wr) begin
            flag_nxt = sw.val;
        end else if (mode == TRIG_LEVEL) begin
            if (evt.valid) flag_nxt = ~evt.level;
        end else begin
            if (evt.fall)  flag_nxt = 1'b1;
            else if (ack)  flag_nxt = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= flag_nxt;
    end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
    import eid_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mc_stb,
    input  logic pin_raw,
    input  logic mode_wr_en,
    input  logic mode_wr_val,
    input  logic sw_wr_en,
    input  logic sw_wr_val,
    input  logic vec_ack,
    output logic req_flag,
    output logic trig_mode
);
    logic       pin_sync;
    smp_evt_t   smp_evt;
    sw_cmd_t    sw_cmd;
    trig_mode_e mode_q;
    logic       smp_lvl;
    logic       smp_fall;

    assign sw_cmd.wr  = sw_wr_en;
    assign sw_cmd.val = sw_wr_val;
    assign smp_lvl    = smp_evt.level;
    assign smp_fall   = smp_evt.fall;

    eid_sync #(
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIN_IDLE)
    ) i_sync (
        .clk(clk),
        .rst(rst),
        .d  (pin_raw),
        .q  (pin_sync)
    );

    eid_sampler i_sampler (
        .clk(clk),
        .rst(rst),
        .stb(mc_stb),
        .din(pin_sync),
        .evt(smp_evt)
    );

    eid_mode_reg i_mode (
        .clk   (clk),
        .rst   (rst),
        .wr_en (mode_wr_en),
        .wr_val(mode_wr_val),
        .mode  (mode_q)
    );

    eid_flag i_flag (
        .clk (clk),
        .rst (rst),
        .mode(mode_q),
        .evt (smp_evt),
        .sw  (sw_cmd),
        .ack (vec_ack),
        .flag(req_flag)
    );

    assign trig_mode = mode_q;
endmodule

// File: rtl/eid_checker.sv
module eid_checker (
    input logic clk,
    input logic rst,
    input logic mode,
    input logic stb,
    input logic smp_lvl,
    input logic fall,
    input logic sw_wr,
    input logic sw_val,
    input logic mode_wr,
    input logic mode_val,
    input logic ack,
    input logic flag
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R8: state straight after a reset cycle
    always_ff @(posedge clk) begin
        if (rst_d && !rst) begin
            p_reset_state_r8: assert (flag == 1'b0 && mode == 1'b0)
                else $error("reset state wrong");
        end
    end

    p_level_follow_r1: assert property (@(posedge clk) disable iff (rst)
        (mode == 1'b0 && stb && !sw_wr) |=> (flag == !$past(smp_lvl)));

    p_edge_set_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == 1'b1 && fall && !sw_wr) |=> flag);

    p_edge_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == 1'b1 && !fall && !ack && !sw_wr) |=> $stable(flag));

    p_edge_ack_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == 1'b1 && ack && !fall && !sw_wr) |=> !flag);

    p_level_noack_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == 1'b0 && !stb && !sw_wr) |=> $stable(flag));

    p_sw_write_r6: assert property (@(posedge clk) disable iff (rst)
        sw_wr |=> (flag == $past(sw_val)));

    p_fall_beats_ack_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == 1'b1 && fall && ack && !sw_wr) |=> flag);

    p_mode_write_r9: assert property (@(posedge clk) disable iff (rst)
        mode_wr |=> (mode == $past(mode_val)));
endmodule

bind ext_irq_detect eid_checker i_eid_checker (
    .clk     (clk),
    .rst     (rst),
    .mode    (trig_mode),
    .stb     (mc_stb),
    .smp_lvl (smp_lvl),
    .fall    (smp_fall),
    .sw_wr   (sw_wr_en),
    .sw_val  (sw_wr_val),
    .mode_wr (mode_wr_en),
    .mode_val(mode_wr_val),
    .ack     (vec_ack),
    .flag    (req_flag)
);

// File: tb/test_ext_irq_detect.sv
module test_ext_irq_detect;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mc_stb = 1'b0;
    logic pin_raw = 1'b1;
    logic mode_wr_en = 1'b0;
    logic mode_wr_val = 1'b0;
    logic sw_wr_en = 1'b0;
    logic sw_wr_val = 1'b0;
    logic vec_ack = 1'b0;
    logic req_flag;
    logic trig_mode;

    always #4 clk = ~clk;

    ext_irq_detect i_ext_irq_detect (
        .clk        (clk),
        .rst        (rst),
        .mc_stb     (mc_stb),
        .pin_raw    (pin_raw),
        .mode_wr_en (mode_wr_en),
        .mode_wr_val(mode_wr_val),
        .sw_wr_en   (sw_wr_en),
        .sw_wr_val  (sw_wr_val),
        .vec_ack    (vec_ack),
        .req_flag   (req_flag),
        .trig_mode  (trig_mode)
    );

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 0;
    string tag = "R8";

    // stimulus state
    logic  pin_v = 1'b1;
    int    stb_per = 12;
    int    stb_cnt = 0;

    // reference model
    logic  pq[$];
    logic  m_flag = 1'b0;
    logic  m_mode = 1'b0;
    logic  m_last = 1'b1;
    logic  m_s;
    logic  m_nf;

    task automatic chk(input logic cond, input string req, input string what,
                       input logic act, input logic exp);
        n_checks++;
        if (!cond) begin
            n_errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            pq = {1'b1, 1'b1};
            m_flag = 1'b0; m_mode = 1'b0; m_last = 1'b1;
        end else begin
            pq.push_back(pin_raw);
            m_s = pq.pop_front();
            m_nf = m_flag;
            if (sw_wr_en)            m_nf = sw_wr_val;
            else if (m_mode == 1'b0) begin
                if (mc_stb) m_nf = !m_s;
            end else begin
                if (mc_stb && m_last && !m_s) m_nf = 1'b1;
                else if (vec_ack)             m_nf = 1'b0;
            end
            if (mc_stb)     m_last = m_s;
            if (mode_wr_en) m_mode = mode_wr_val;
            m_flag = m_nf;
        end
        #2;
        if (!done) begin
            chk(req_flag === m_flag, tag, "req_flag", req_flag, m_flag);
            chk(trig_mode === m_mode, "R9", "trig_mode", trig_mode, m_mode);
        end
    end

    function automatic bit stb_due();
        return stb_cnt == stb_per - 1;
    endfunction

    task automatic tick(input logic a, input logic sw, input logic sv,
                        input logic mw, input logic mv);
        @(negedge clk);
        pin_raw     = pin_v;
        vec_ack     = a;
        sw_wr_en    = sw;
        sw_wr_val   = sv;
        mode_wr_en  = mw;
        mode_wr_val = mv;
        mc_stb      = stb_due();
        stb_cnt     = stb_due() ? 0 : stb_cnt + 1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0);
    endtask

    // advance until the next tick is a strobe, then drive that tick
    task automatic at_strobe(input logic a, input logic sw, input logic sv);
        while (!stb_due()) tick(0, 0, 0, 0, 0);
        tick(a, sw, sv, 0, 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    logic [15:0] lfsr = 16'hACE1;

    initial begin
        // R8: reset, then explicit reset-state check
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_flag == 1'b0, "R8", "flag after reset", req_flag, 1'b0);
        chk(trig_mode == 1'b0, "R8", "mode after reset", trig_mode, 1'b0);

        // R1: level mode follows samples
        tag = "R1";
        idle(14);
        pin_v = 1'b0; idle(26);
        chk(req_flag == 1'b1, "R1", "low pin level request", req_flag, 1'b1);
        pin_v = 1'b1; idle(26);
        chk(req_flag == 1'b0, "R1", "high pin level release", req_flag, 1'b0);

        // R5: acknowledge ignored in level mode, request persists
        tag = "R5";
        pin_v = 1'b0; idle(26);
        tick(1, 0, 0, 0, 0);
        chk(req_flag == 1'b1, "R5", "ack ignored in level", req_flag, 1'b1);
        idle(13);
        chk(req_flag == 1'b1, "R5", "still low re-requests", req_flag, 1'b1);

        // R3: short high pulse between strobes is not seen in level mode
        tag = "R3";
        at_strobe(0, 0, 0);
        pin_v = 1'b1; idle(3);
        pin_v = 1'b0; idle(20);
        chk(req_flag == 1'b1, "R3", "pulse between strobes ignored", req_flag, 1'b1);

        // R9 then R8 corner: switch to edge with pin low, first sample counts as fall
        tag = "R8";
        pin_v = 1'b1; idle(26);
        tick(0, 1, 0, 0, 0);
        rst = 1'b1; idle(2); rst = 1'b0;
        pin_v = 1'b0;
        tick(0, 0, 0, 1, 1);
        idle(26);
        chk(req_flag == 1'b1, "R8", "low first sample is a fall", req_flag, 1'b1);

        // R4: acknowledge clears in edge mode
        tag = "R4";
        tick(1, 0, 0, 0, 0);
        idle(1);
        chk(req_flag == 1'b0, "R4", "edge ack clears", req_flag, 1'b0);
        idle(26);
        chk(req_flag == 1'b0, "R4", "low level no re-request in edge", req_flag, 1'b0);

        // R2: fresh falling edge
        tag = "R2";
        pin_v = 1'b1; idle(26);
        pin_v = 1'b0; idle(26);
        chk(req_flag == 1'b1, "R2", "falling edge sets", req_flag, 1'b1);
        tick(1, 0, 0, 0, 0);

        // R7: fall and ack in one cycle
        tag = "R7";
        pin_v = 1'b1; idle(26);
        at_strobe(0, 0, 0);
        pin_v = 1'b0;
        at_strobe(1, 0, 0);
        idle(1);
        chk(req_flag == 1'b1, "R7", "fall wins over ack", req_flag, 1'b1);

        // R6: software write overrides
        tag = "R6";
        tick(0, 1, 0, 0, 0);
        idle(1);
        chk(req_flag == 1'b0, "R6", "sw clear", req_flag, 1'b0);
        tick(0, 1, 1, 0, 0);
        tick(1, 0, 0, 0, 0);
        pin_v = 1'b1; idle(26);
        at_strobe(0, 0, 0);
        pin_v = 1'b0;
        at_strobe(1, 1, 0);
        idle(1);
        chk(req_flag == 1'b0, "R6", "sw clear beats fall", req_flag, 1'b0);

        // R3: dense random mix, short strobe interval
        tag = "R3";
        stb_per = 3;
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[2:0] == 3'd0) pin_v = ~pin_v;
            tick(lfsr[5:3] == 3'd0, lfsr[9:6] == 4'd0, lfsr[10],
                 lfsr[15:11] == 5'd0, lfsr[1]);
        end
        idle(4);
        finish_run();
    end
endmodule